// File: doc/BRIEF.md
# Horizontal Blanking Generator with Clock Masking

This block produces the horizontal blanking window for a line-scanned image sensor and, while that window is open, holds the four horizontal shift-clock phases at fixed levels. Four blanking sequences are held in configuration. Each one has an opening pixel position, a closing pixel position and one mask bit. The frame is split into regions by line number. Region 0 always starts at line 0, and three programmable line boundaries open regions 1 to 3. Each region has a pointer that picks which of the four sequences applies while the line count is in that region.

The free-running clock phases H1 to H4 come in from outside the block. Outside blanking they pass through unchanged. Inside blanking, H1 and H3 take the mask level and H2 and H4 take the inverse. The blanking flag and the four clock outputs are registered in the same flop stage, so the two can never disagree about which cycle is blanked.

Top module: `hblk_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `blank_o` is 0 and `hclk_o` is 4'b0000.
- R2: `blank_o` is 1 in the cycle after a clock edge at which `pix_i` satisfies start <= pix_i < end for the selected sequence. Otherwise it is 0. There is no start-polarity option: the window is always active high.
- R3: A sequence whose start is greater than or equal to its end never raises `blank_o`.
- R4: While `blank_o` is 1 and the selected sequence's mask bit is 1, `hclk_o` is 4'b0101. The bit order is bit0=H1, bit1=H2, bit2=H3, bit3=H4. So H1=H3=1 and H2=H4=0.
- R5: While `blank_o` is 1 and the mask bit is 0, `hclk_o` is 4'b1010. So H1=H3=0 and H2=H4=1.
- R6: While `blank_o` is 0, `hclk_o` equals the value `hclk_i` had one cycle earlier.
- R7: The region is the highest k in 1..3 for which `line_i` >= boundary k. If no boundary is reached, the region is 0. Boundary k sits at `bnd_i[(k-1)*LINE_W +: LINE_W]`.
- R8: The sequence used in region r is `ptr_i[r*SEQ_W +: SEQ_W]`. Sequence s takes its start, end and mask from `seq_start_i[s*PIX_W +: PIX_W]`, `seq_end_i[s*PIX_W +: PIX_W]` and `seq_mask_i[s]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_i | input | PIX_W | Pixel position within the line |
| line_i | input | LINE_W | Line position within the field |
| hclk_i | input | 4 | Free-running H1..H4 phases (bit0=H1) |
| seq_start_i | input | NSEQ*PIX_W | Blanking opening position per sequence |
| seq_end_i | input | NSEQ*PIX_W | Blanking closing position per sequence |
| seq_mask_i | input | NSEQ | Level of H1/H3 during blanking per sequence |
| bnd_i | input | (NREG-1)*LINE_W | Line boundaries opening regions 1..3 |
| ptr_i | input | NREG*SEQ_W | Sequence pointer per region |
| blank_o | output | 1 | Blanking window, active high |
| hclk_o | output | 4 | Gated H1..H4 phases |

## Verification
The bench builds the block with PIX_W=6 and LINE_W=5, and keeps four sequences and four regions. With these narrow counters, random pixel and line values land inside windows, on window edges and on region boundaries often. Random configurations then produce reversed and empty windows, equal boundaries and shared pointers without any extra steering. Directed cases cover the exact first and last blanked pixel, each boundary line, and pointer remapping.

// File: rtl/hblk_pkg.sv
package hblk_pkg;
  localparam int HCLK_N = 4;

  // Fixed phase levels during blanking: H1/H3 = m, H2/H4 = ~m
  function automatic logic [HCLK_N-1:0] force_pattern(input logic m);
    return {~m, m, ~m, m};
  endfunction
endpackage

// File: rtl/hblk_region_sel.sv
module hblk_region_sel #(
  parameter int LINE_W = 12,
  parameter int NREG   = 4,
  parameter int SEQ_W  = 2,
  parameter int RIDX_W = $clog2(NREG)
) (
  input  logic [LINE_W-1:0]          line_i,
  input  logic [(NREG-1)*LINE_W-1:0] bnd_i,
  input  logic [NREG*SEQ_W-1:0]      ptr_i,
  output logic [RIDX_W-1:0]          region_o,
  output logic [SEQ_W-1:0]           seq_o
);
  // Later boundaries override earlier ones: highest reached region wins
  always_comb begin
    region_o = '0;
    for (int k = 1; k < NREG; k++) begin
      if (line_i >= bnd_i[(k-1)*LINE_W +: LINE_W])
        region_o = RIDX_W'(k);
    end
    seq_o = ptr_i[region_o*SEQ_W +: SEQ_W];
  end
endmodule

// File: rtl/hblk_window.sv
module hblk_window #(
  parameter int PIX_W = 12,
  parameter int NSEQ  = 4
) (
  input  logic [PIX_W-1:0]      pix_i,
  input  logic [NSEQ*PIX_W-1:0] start_i,
  input  logic [NSEQ*PIX_W-1:0] end_i,
  output logic [NSEQ-1:0]       hit_o
);
  // One half-open window comparator per sequence
  for (genvar g = 0; g < NSEQ; g++) begin : g_cmp
    assign hit_o[g] = (pix_i >= start_i[g*PIX_W +: PIX_W]) &&
                      (pix_i <  end_i[g*PIX_W +: PIX_W]);
  end
endmodule

// File: rtl/hblk_gen.sv
module hblk_gen #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 12,
  parameter int NSEQ   = 4,
  parameter int NREG   = 4,
  parameter int SEQ_W  = $clog2(NSEQ)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PIX_W-1:0]           pix_i,
  input  logic [LINE_W-1:0]          line_i,
  input  logic [3:0]                 hclk_i,
  input  logic [NSEQ*PIX_W-1:0]      seq_start_i,
  input  logic [NSEQ*PIX_W-1:0]      seq_end_i,
  input  logic [NSEQ-1:0]            seq_mask_i,
  input  logic [(NREG-1)*LINE_W-1:0] bnd_i,
  input  logic [NREG*SEQ_W-1:0]      ptr_i,
  output logic                       blank_o,
  output logic [3:0]                 hclk_o
);
  import hblk_pkg::*;

  localparam int RIDX_W = $clog2(NREG);

  logic [RIDX_W-1:0] region;
  logic [SEQ_W-1:0]  seq;
  logic [NSEQ-1:0]   hit;
  logic              win;
  logic              mask_lvl;

  hblk_region_sel #(
    .LINE_W(LINE_W), .NREG(NREG), .SEQ_W(SEQ_W), .RIDX_W(RIDX_W)
  ) u_region (
    .line_i(line_i), .bnd_i(bnd_i), .ptr_i(ptr_i),
    .region_o(region), .seq_o(seq)
  );

  hblk_window #(.PIX_W(PIX_W), .NSEQ(NSEQ)) u_window (
    .pix_i(pix_i), .start_i(seq_start_i), .end_i(seq_end_i), .hit_o(hit)
  );

  assign win      = hit[seq];
  assign mask_lvl = seq_mask_i[seq];

  // Flag and phases share one register stage so they stay aligned
  always_ff @(posedge clk) begin
    if (rst) begin
      blank_o <= 1'b0;
      hclk_o  <= '0;
    end else begin
      blank_o <= win;
      hclk_o  <= win ? force_pattern(mask_lvl) : hclk_i;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!blank_o && hclk_o == 4'b0000)); // R1

  AST_BLANK_TRACK: assert property (@(posedge clk) disable iff (rst)
    win |=> blank_o); // R2

  AST_PHASE_PAIR: assert property (@(posedge clk) disable iff (rst)
    blank_o |-> (hclk_o[0] == hclk_o[2] && hclk_o[1] == hclk_o[3] &&
                 hclk_o[1] != hclk_o[0])); // R4

  AST_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    !win |=> (hclk_o == $past(hclk_i))); // R6

  AST_REGION_BASE: assert property (@(posedge clk) disable iff (rst)
    (line_i < bnd_i[LINE_W-1:0] && line_i < bnd_i[2*LINE_W-1:LINE_W] &&
     line_i < bnd_i[3*LINE_W-1:2*LINE_W]) |-> (region == '0)); // R7
endmodule

// File: tb/hblk_gen_test.sv
module hblk_gen_test;
  localparam int PW = 6;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] pix = '0;
  logic [LW-1:0] line = '0;
  logic [3:0] hin = '0;
  logic [PW-1:0] st [4];
  logic [PW-1:0] en [4];
  logic [3:0] mk;
  logic [LW-1:0] bd [3];
  logic [1:0] pt [4];
  logic [4*PW-1:0] st_f, en_f;
  logic [3*LW-1:0] bd_f;
  logic [7:0] pt_f;
  logic blank;
  logic [3:0] hout;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      st_f[i*PW +: PW] = st[i];
      en_f[i*PW +: PW] = en[i];
      pt_f[i*2 +: 2]   = pt[i];
    end
    for (int i = 0; i < 3; i++) bd_f[i*LW +: LW] = bd[i];
  end

  hblk_gen #(.PIX_W(PW), .LINE_W(LW), .NSEQ(4), .NREG(4)) uut (
    .clk(clk), .rst(rst), .pix_i(pix), .line_i(line), .hclk_i(hin),
    .seq_start_i(st_f), .seq_end_i(en_f), .seq_mask_i(mk),
    .bnd_i(bd_f), .ptr_i(pt_f), .blank_o(blank), .hclk_o(hout)
  );

  function automatic int sel_seq(input logic [LW-1:0] l);
    int r = 0;
    for (int k = 1; k < 4; k++) if (l >= bd[k-1]) r = k;
    return int'(pt[r]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs applied at negedge, outputs checked at the following negedge
  task automatic cyc(input int p, input int l, input int h, input string tag);
    int s;
    bit eb;
    logic [3:0] eh;
    string ht;
    pix = PW'(p); line = LW'(l); hin = 4'(h);
    s  = sel_seq(line);
    eb = (pix >= st[s]) && (pix < en[s]);
    eh = eb ? {~mk[s], mk[s], ~mk[s], mk[s]} : hin;
    ht = eb ? (mk[s] ? "R4" : "R5") : "R6";
    @(posedge clk); @(negedge clk);
    chk(blank == eb, tag, int'(blank), int'(eb));
    chk(hout == eh, {ht, "/", tag}, int'(hout), int'(eh));
  endtask

  task automatic rand_cfg();
    for (int i = 0; i < 4; i++) begin
      st[i] = PW'($urandom); en[i] = PW'($urandom);
      mk[i] = 1'($urandom); pt[i] = 2'($urandom);
    end
    for (int i = 0; i < 3; i++) bd[i] = LW'($urandom);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    st = '{6'd10, 6'd5, 6'd30, 6'd40};
    en = '{6'd20, 6'd8, 6'd30, 6'd10};
    mk = 4'b0001;
    bd = '{5'd8, 5'd16, 5'd24};
    pt = '{2'd0, 2'd1, 2'd2, 2'd3};

    // R1: reset holds outputs low even with a window hit and active phases
    pix = 6'd12; hin = 4'hF;
    @(negedge clk); @(negedge clk);
    chk(blank == 1'b0, "R1", int'(blank), 0);
    chk(hout == 4'h0, "R1", int'(hout), 0);
    @(negedge clk);
    rst = 1'b0;
    chk(blank == 1'b0 && hout == 4'h0, "R1", int'(hout), 0);

    // R2: window edges for seq 0 (region 0), mask 1
    cyc(9, 0, 4'h3, "R2");
    cyc(10, 0, 4'h3, "R2");
    cyc(19, 0, 4'hC, "R2");
    cyc(20, 0, 4'hC, "R2");
    // R7: boundary lines, seq 1 window 5..7, mask 0
    cyc(6, 7, 4'h6, "R7");
    cyc(6, 8, 4'h6, "R7");
    cyc(6, 15, 4'h9, "R7");
    cyc(12, 16, 4'h9, "R7");
    // R3: empty and reversed windows
    cyc(30, 20, 4'h5, "R3");
    cyc(45, 24, 4'hA, "R3");
    cyc(5, 31, 4'h1, "R3");
    // R8: remap region 0 to seq 1 and region 3 to seq 0
    @(negedge clk);
    pt[0] = 2'd1; pt[3] = 2'd0;
    cyc(6, 0, 4'h2, "R8");
    cyc(12, 0, 4'h2, "R8");
    cyc(12, 28, 4'h4, "R8");
    cyc(6, 28, 4'h4, "R8");

    // Random configurations and stimulus
    for (int b = 0; b < 40; b++) begin
      rand_cfg();
      for (int c = 0; c < 50; c++)
        cyc(int'($urandom % 64), int'($urandom % 32), int'($urandom % 16), "R2");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule